// File: doc/BRIEF.md
# Four-channel reloading down-counter timer

The block holds four independent 32-bit down counters behind a simple register bus with address, write data, write enable, read enable and read data. A channel that is enabled counts down by one on every tick. When it passes through zero it sets a sticky timeout flag, raises its interrupt if the interrupt is enabled, and reloads itself from its reload register, so it runs periodically with no help from software. A shared halt bit in the module control register stops every channel at once. Any channel above channel 0 can be linked to the channel below it. It then counts that neighbour's expirations instead of clock cycles, and a linked pair behaves as one 64-bit timer.

Software changes a period in one of two ways. It can write the reload register, and the new value takes effect at the next natural reload. Or it can also drop and raise the run bit, which restarts the count at once from the new value. Flags are cleared by writing a one. The bus is a plain register port with no stream traffic, so it has no valid/ready handshake: a write takes effect at the clock edge where the write enable is high. Read data is registered. It appears in the cycle after the read enable and holds until the next read.

Top module: `mc_timer`

## Requirements
- R1: After reset the module control register (offset 0x000) reads 0x2. Every channel register reads 0, every interrupt output is low, and a read of an unmapped address returns 0.
- R2: Bit 1 of the module control register is the halt bit. While it is 1, no channel's count register changes except through the start load of R7. Writing 0 to it lets the channels count.
- R3: Channel n's registers start at 0x100 + 0x10*n: reload at +0x0, count at +0x4, control at +0x8 and status at +0xC. The count register is read-only, and writes to it are ignored. Read data appears in the cycle after rd_en is sampled high.
- R4: Control register bits: bit 0 is run, bit 1 is interrupt enable and bit 2 is link. The control register reads back the bits that were written.
- R5: On each tick, a running channel decrements. On a tick where the count is 0, the channel instead reloads from its reload register and sets its flag. The period is therefore reload+1 ticks, and an unlinked channel ticks on every clock while not halted. The link bit of channel 0 has no effect.
- R6: Writing the reload register while a channel runs leaves the count in progress undisturbed. The new value is used at the next reload.
- R7: A control write that changes run from 0 to 1 loads the count from the reload register in that cycle. The flag is then set reload+1 clocks after that write edge.
- R8: A channel whose run bit is 0 holds its count. Reading the count has no side effect.
- R9: A channel n>0 with link set decrements once for each expiry of channel n-1 and never otherwise. It expires when its count is 0 and channel n-1 expires.
- R10: Status bit 0 is the timeout flag. Writing 1 clears it and writing 0 does nothing. If an expiry falls in the same cycle as a clear, the flag stays set.
- R11: irq[n] is high exactly when channel n's flag and its interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW (12) | Byte address of the register access |
| wr_data | input | DW (32) | Write data |
| wr_en | input | 1 | Write strobe, one register per cycle |
| rd_en | input | 1 | Read strobe; data is registered |
| rd_data | output | DW (32) | Read data, valid the cycle after rd_en |
| irq | output | NCH (4) | Per-channel interrupt request |

## Verification
The bench measures periods to the exact clock. An off-by-one reload, or a start that does not load from the reload register, shows up as an interrupt one edge early or late. It writes a new reload value mid-period and checks that the first expiry still comes at the old time and the next one follows the new period; a design that restarted on the reload write would expire early. It places a flag clear on the exact expiry edge, where a design that let the clear win would read the flag as 0. It also checks that a linked channel stays frozen until its neighbour expires, and that the linked channel's flag rises only on the edge where both counts wrap together. A design that chained on the wrong channel, or counted clocks, would show the wrong count.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;

  // control register fields
  localparam int CTL_RUN  = 0;
  localparam int CTL_IEN  = 1;
  localparam int CTL_LINK = 2;
  localparam int CTL_W    = 3;

  // module control field
  localparam int MOD_HALT = 1;

  // register map
  localparam int CHAN_BASE   = 'h100;
  localparam int CHAN_STRIDE = 'h10;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTL    = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic link;
    logic ien;
    logic run;
  } ctl_t;

endpackage

// File: rtl/mc_timer_dec.sv
module mc_timer_dec
  import mc_timer_pkg::*;
#(
  parameter int AW  = 12,
  parameter int NCH = 4
) (
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  output logic           mod_hit,
  output logic [NCH-1:0] chan_hit,
  output reg_sel_e       sel,
  output logic           mod_wr,
  output logic [NCH-1:0] wr_reload,
  output logic [NCH-1:0] wr_ctl,
  output logic [NCH-1:0] wr_stat
);

  logic aligned;

  assign aligned = (addr[1:0] == 2'b00);
  assign mod_hit = (addr == '0);
  assign mod_wr  = wr_en & mod_hit;
  assign sel     = reg_sel_e'(addr[3:2]);

  for (genvar i = 0; i < NCH; i++) begin : gen_hit
    localparam logic [AW-1:0] BLK = AW'(CHAN_BASE + CHAN_STRIDE * i);
    assign chan_hit[i]  = aligned && (addr[AW-1:4] == BLK[AW-1:4]);
    assign wr_reload[i] = wr_en & chan_hit[i] & (sel == SEL_RELOAD);
    assign wr_ctl[i]    = wr_en & chan_hit[i] & (sel == SEL_CTL);
    assign wr_stat[i]   = wr_en & chan_hit[i] & (sel == SEL_STAT);
  end

endmodule

// File: rtl/mc_timer_chan.sv
module mc_timer_chan
  import mc_timer_pkg::*;
#(
  parameter int W        = 32,
  parameter bit HAS_PREV = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt,
  input  logic         prev_expire,
  input  logic         wr_reload,
  input  logic         wr_ctl,
  input  logic         wr_stat,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] count_q,
  output ctl_t         ctl_q,
  output logic         flag_q,
  output logic         expire,
  output logic         irq
);

  logic link_eff;
  logic tick;
  logic start;
  logic at_zero;

  // channel 0 has no lower neighbour, so its link bit is ignored
  if (HAS_PREV) begin : gen_link
    assign link_eff = ctl_q.link;
  end else begin : gen_nolink
    assign link_eff = 1'b0;
  end

  assign at_zero = (count_q == '0);
  assign tick    = ctl_q.run & ~halt & (link_eff ? prev_expire : 1'b1);
  assign expire  = tick & at_zero;
  assign start   = wr_ctl & wdata[CTL_RUN] & ~ctl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (wr_reload) begin
      reload_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (start) begin
      count_q <= reload_q;
    end else if (expire) begin
      count_q <= reload_q;
    end else if (tick) begin
      count_q <= count_q - 1'b1;
    end
  end

  // expiry has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (wr_stat && wdata[0]) begin
      flag_q <= 1'b0;
    end
  end

  assign irq = flag_q & ctl_q.ien;

endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import mc_timer_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_en,
  input  logic           rd_en,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] irq
);

  logic           mod_hit;
  logic [NCH-1:0] chan_hit;
  reg_sel_e       sel;
  logic           mod_wr;
  logic [NCH-1:0] wr_reload;
  logic [NCH-1:0] wr_ctl;
  logic [NCH-1:0] wr_stat;
  logic           halt_q;

  logic [NCH-1:0][DW-1:0] reload_all;
  logic [NCH-1:0][DW-1:0] count_all;
  logic [NCH-1:0]         run_all;
  logic [NCH-1:0]         ien_all;
  logic [NCH-1:0]         link_all;
  logic [NCH-1:0]         flag_all;
  logic [DW-1:0]          rd_val;

  mc_timer_dec #(.AW(AW), .NCH(NCH)) u_dec (
    .addr      (addr),
    .wr_en     (wr_en),
    .mod_hit   (mod_hit),
    .chan_hit  (chan_hit),
    .sel       (sel),
    .mod_wr    (mod_wr),
    .wr_reload (wr_reload),
    .wr_ctl    (wr_ctl),
    .wr_stat   (wr_stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
    end else if (mod_wr) begin
      halt_q <= wr_data[MOD_HALT];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : gen_ch
    logic exp_o;
    logic prev_exp;
    ctl_t ctl_o;

    if (i == 0) begin : gen_first
      assign prev_exp = 1'b0;
    end else begin : gen_next
      assign prev_exp = gen_ch[i-1].exp_o;
    end

    mc_timer_chan #(.W(DW), .HAS_PREV(i != 0)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt        (halt_q),
      .prev_expire (prev_exp),
      .wr_reload   (wr_reload[i]),
      .wr_ctl      (wr_ctl[i]),
      .wr_stat     (wr_stat[i]),
      .wdata       (wr_data),
      .reload_q    (reload_all[i]),
      .count_q     (count_all[i]),
      .ctl_q       (ctl_o),
      .flag_q      (flag_all[i]),
      .expire      (exp_o),
      .irq         (irq[i])
    );

    assign run_all[i]  = ctl_o.run;
    assign ien_all[i]  = ctl_o.ien;
    assign link_all[i] = ctl_o.link;
  end

  always_comb begin
    rd_val = '0;
    if (mod_hit) begin
      rd_val[MOD_HALT] = halt_q;
    end
    for (int i = 0; i < NCH; i++) begin
      if (chan_hit[i]) begin
        unique case (sel)
          SEL_RELOAD: rd_val = reload_all[i];
          SEL_COUNT:  rd_val = count_all[i];
          SEL_CTL: begin
            rd_val[CTL_RUN]  = run_all[i];
            rd_val[CTL_IEN]  = ien_all[i];
            rd_val[CTL_LINK] = link_all[i];
          end
          SEL_STAT:   rd_val[0] = flag_all[i];
          default:    rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_val;
    end
  end

endmodule

// File: rtl/mc_timer_chk.sv
module mc_timer_chk
  import mc_timer_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          addr,
  input logic [DW-1:0]          wr_data,
  input logic                   wr_en,
  input logic                   halt,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         link,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0][DW-1:0] count
);

  for (genvar i = 0; i < NCH; i++) begin : gen_chk
    localparam logic [AW-1:0] CTL_A  = AW'(CHAN_BASE + CHAN_STRIDE * i + 8);
    localparam logic [AW-1:0] STAT_A = AW'(CHAN_BASE + CHAN_STRIDE * i + 12);
    logic ctl_wr;
    assign ctl_wr = wr_en && (addr == CTL_A);

    // R2: halt freezes the count unless a start load happens
    p_halt_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !ctl_wr) |=> $stable(count[i]));

    // R8: a stopped channel holds its count
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !ctl_wr) |=> $stable(count[i]));

    // R10: the flag only rises as the count wraps from zero
    p_flag_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> ($past(count[i]) == '0));

    // R10: the flag only falls after a write of 1 to its status register
    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(wr_en && (addr == STAT_A) && wr_data[0]));

    if (i == 0) begin : gen_step0
      // R5: one step down per clock (link ignored on channel 0)
      p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run[i] && !halt && (count[i] != '0) && !ctl_wr)
        |=> (count[i] == $past(count[i]) - 1'b1));
    end else begin : gen_stepn
      // R5: one step down per clock when not linked
      p_down_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run[i] && !link[i] && !halt && (count[i] != '0) && !ctl_wr)
        |=> (count[i] == $past(count[i]) - 1'b1));

      // R9: a linked channel waits while its neighbour is not at zero
      p_link_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link[i] && (count[i-1] != '0) && !ctl_wr) |=> $stable(count[i]));
    end
  end

endmodule

bind mc_timer mc_timer_chk #(.AW(AW), .DW(DW), .NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_data (wr_data),
  .wr_en   (wr_en),
  .halt    (halt_q),
  .run     (run_all),
  .link    (link_all),
  .flag    (flag_all),
  .count   (count_all)
);

// File: tb/mc_timer_tb.sv
module mc_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic           wr_en = 1'b0;
  logic           rd_en = 1'b0;
  logic [DW-1:0]  rd_data;
  logic [NCH-1:0] irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_timer #(.AW(AW), .DW(DW), .NCH(NCH)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq     (irq)
  );

  function automatic logic [AW-1:0] ra(input int ch, input int off);
    return AW'(32'h100 + 32'h10 * ch + off);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // edges from now until irq[ch] is seen high
  task automatic wait_irq(input int ch, output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (!irq[ch] && n < 200);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    rd(12'h000, d); check("R1 module reg reset", d, 32'h2);
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < 16; o += 4) begin
        rd(ra(c, o), d); check("R1 channel reg reset", d, 32'h0);
      end
    end
    rd(12'h080, d); check("R1 unmapped read", d, 32'h0);
    check("R1 irq reset", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_halt;
    logic [DW-1:0] d;
    wr(ra(0, 0), 32'd5);
    wr(ra(0, 8), 32'h1);
    repeat (6) @(posedge clk);
    rd(ra(0, 4), d); check("R2 halted count", d, 32'd5);
    wr(12'h000, 32'h0);
    rd(12'h000, d); check("R2 halt cleared", d, 32'h0);
    rd(ra(0, 4), d); check("R2 counts after unhalt", d, 32'd4);
    wr(ra(0, 8), 32'h0);
    wr(ra(0, 12), 32'h1);
  endtask

  task automatic t_period;
    logic [DW-1:0] d;
    int n;
    wr(ra(0, 0), 32'd4);
    wr(ra(0, 12), 32'h1);
    wr(ra(0, 8), 32'h7);
    wait_irq(0, n);
    check("R5 R7 period reload+1 with ch0 link ignored", n, 32'd5);
    rd(ra(0, 8), d); check("R4 control readback", d, 32'h7);
    rd(ra(0, 4), d); check("R5 reload after wrap", d, 32'd3);
    rd(ra(0, 0), d); check("R3 reload readback", d, 32'd4);
    wr(ra(0, 8), 32'h0);
    wr(ra(0, 12), 32'h1);
  endtask

  task automatic t_reload_live;
    int n;
    wr(ra(2, 0), 32'd10);
    wr(ra(2, 12), 32'h1);
    wr(ra(2, 8), 32'h3);
    wr(ra(2, 0), 32'd3);
    wait_irq(2, n);
    check("R6 first expiry keeps old period", n, 32'd10);
    wr(ra(2, 12), 32'h1);
    wait_irq(2, n);
    check("R6 next period uses new reload", n, 32'd3);
    wr(ra(2, 8), 32'h0);
    wr(ra(2, 12), 32'h1);
  endtask

  task automatic t_restart;
    logic [DW-1:0] a, b, c;
    int n;
    wr(ra(3, 0), 32'd20);
    wr(ra(3, 8), 32'h1);
    repeat (5) @(posedge clk);
    wr(ra(3, 0), 32'd2);
    wr(ra(3, 8), 32'h0);
    rd(ra(3, 4), a);
    repeat (4) @(posedge clk);
    rd(ra(3, 4), b); check("R8 stopped count holds", b, a);
    rd(ra(3, 4), c); check("R8 read has no side effect", c, a);
    wr(ra(3, 4), 32'h55);
    rd(ra(3, 4), c); check("R3 count write ignored", c, a);
    wr(ra(3, 12), 32'h1);
    wr(ra(3, 8), 32'h3);
    wait_irq(3, n);
    check("R7 restart loads new reload", n, 32'd3);
    wr(ra(3, 8), 32'h0);
    wr(ra(3, 12), 32'h1);
  endtask

  task automatic t_chain;
    logic [DW-1:0] d;
    wr(ra(1, 0), 32'd5);
    wr(ra(1, 12), 32'h1);
    wr(ra(1, 8), 32'h5);
    repeat (4) @(posedge clk);
    rd(ra(1, 4), d); check("R9 linked channel idle without expiry", d, 32'd5);
    wr(ra(0, 0), 32'd2);
    wr(ra(0, 8), 32'h1);
    repeat (9) @(posedge clk);
    rd(ra(1, 4), d); check("R9 linked count after three expiries", d, 32'd2);
    repeat (7) @(posedge clk);
    rd(ra(1, 12), d); check("R9 linked flag not yet set", d, 32'h0);
    rd(ra(1, 12), d); check("R9 linked flag on joint wrap", d, 32'h1);
    wr(ra(0, 8), 32'h0);
    wr(ra(1, 8), 32'h0);
    wr(ra(0, 12), 32'h1);
    wr(ra(1, 12), 32'h1);
  endtask

  task automatic t_flag;
    logic [DW-1:0] d;
    wr(ra(0, 0), 32'd3);
    wr(ra(0, 12), 32'h1);
    wr(ra(0, 8), 32'h1);
    repeat (7) @(posedge clk);
    wr(ra(0, 12), 32'h1);
    rd(ra(0, 12), d); check("R10 expiry beats clear", d, 32'h1);
    check("R11 irq masked when disabled", {31'h0, irq[0]}, 32'h0);
    wr(ra(0, 12), 32'h0);
    rd(ra(0, 12), d); check("R10 write 0 keeps flag", d, 32'h1);
    wr(ra(0, 8), 32'h3);
    check("R11 irq follows enable", {31'h0, irq[0]}, 32'h1);
    wr(ra(0, 12), 32'h1);
    rd(ra(0, 12), d); check("R10 write 1 clears flag", d, 32'h0);
    check("R11 irq low after clear", {31'h0, irq[0]}, 32'h0);
    wr(ra(0, 8), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_halt;
    t_period;
    t_reload_live;
    t_restart;
    t_chain;
    t_flag;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule